// File: doc/BRIEF.md
# Counted Masked Address Breakpoint Unit

This block watches the memory accesses of a processor and raises a breakpoint request once a selected access has been seen a set number of times. It has two independent channels. Each channel holds a base address and a per-bit mask. An access on the snoop port matches a channel when every unmasked address bit equals the base. The access must also meet the channel's direction and access-kind conditions.

Every qualifying event steps a 16-bit down-counter. Software loads the counter with the wanted number of occurrences less one. Events decrement it while it is non-zero. The first event that arrives once it is zero trips the channel. The external request is the registered OR of both channels. It stays high until software rewrites the tripped channel's counter. Rewriting the counter is also how a channel is re-armed after its base, mask or control has changed.

Top module: `bkpt_unit`

## Requirements
- R1: After reset, every base, mask, control and counter register reads 0 and `bkpt_req` is 0.
- R2: An address matches when `((bus_addr ^ base) & ~mask) == 0`. A mask bit of 1 ignores that address bit.
- R3: Control bits [4:0] select the direction. 1 = reads only (`bus_write`=0), 2 = writes only (`bus_write`=1), 3 = either. 0 and every other value disable the channel.
- R4: Control bits [12:8] select the kind. 0 = any, 1 = data only (`bus_fetch`=0), 2 = instruction fetch only (`bus_fetch`=1). Every other value never qualifies.
- R5: A qualifying event sampled while the counter is non-zero decrements the counter by one.
- R6: A qualifying event sampled while the counter is zero trips the channel. `bkpt_req` is high from the clock edge that samples that event.
- R7: While a channel is tripped, `bkpt_req` stays high and further events leave its counter unchanged.
- R8: Writing a channel's counter loads it, clears that channel's trip, and drops `bkpt_req` if the other channel is not tripped. The write wins over an event in the same cycle.
- R9: Register port address = {channel (A=0, B=1), select}. Select 0 = base, 1 = mask, 2 = control, 3 = counter. Reads are registered: `reg_rdata` shows the register addressed at one edge after that edge. Control reads back only bits [12:8] and [4:0].
- R10: The channels count independently, and `bkpt_req` is the OR of both channels' trip states.
- R11: No event is counted in a cycle where `bus_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Snooped access present this cycle |
| bus_addr | input | 32 | Snooped access address |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address {channel, select} |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| bkpt_req | output | 1 | Breakpoint request to the CPU |

## Verification
The assertions assume that address, direction, kind and valid are sampled together once per clock, so each channel sees at most one event per edge. They also assume that a counter write and an event in the same cycle resolve in favour of the write. The stimulus drives every snoop field and register write between edges, holds each for one clock, and changes configuration only with a counter rewrite after it. The same-cycle collision of a write and an event is driven on purpose so that the write's priority is exercised.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  localparam int FLD_W = 5;

  localparam logic [FLD_W-1:0] DIR_RD  = 5'd1;
  localparam logic [FLD_W-1:0] DIR_WR  = 5'd2;
  localparam logic [FLD_W-1:0] DIR_ANY = 5'd3;

  localparam logic [FLD_W-1:0] KIND_ANY   = 5'd0;
  localparam logic [FLD_W-1:0] KIND_DATA  = 5'd1;
  localparam logic [FLD_W-1:0] KIND_FETCH = 5'd2;

  localparam int DIR_LSB  = 0;
  localparam int KIND_LSB = 8;

  typedef enum logic [1:0] {
    SEL_BASE = 2'd0,
    SEL_MASK = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_CNT  = 2'd3
  } reg_sel_e;

  function automatic logic dir_ok(input logic [FLD_W-1:0] f, input logic is_wr);
    case (f)
      DIR_RD:  return !is_wr;
      DIR_WR:  return is_wr;
      DIR_ANY: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic kind_ok(input logic [FLD_W-1:0] f, input logic is_fetch);
    case (f)
      KIND_ANY:   return 1'b1;
      KIND_DATA:  return !is_fetch;
      KIND_FETCH: return is_fetch;
      default:    return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/bkpt_match.sv
module bkpt_match
  import bkpt_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0]    base,
  input  logic [AW-1:0]    mask,
  input  logic [AW-1:0]    addr,
  input  logic             valid,
  input  logic             is_wr,
  input  logic             is_fetch,
  input  logic [FLD_W-1:0] dir_fld,
  input  logic [FLD_W-1:0] kind_fld,
  output logic             evt
);
  logic addr_hit;

  always_comb begin
    addr_hit = ((addr ^ base) & ~mask) == '0;
    evt      = valid && addr_hit && dir_ok(dir_fld, is_wr) && kind_ok(kind_fld, is_fetch);
  end
endmodule

// File: rtl/bkpt_channel.sv
module bkpt_channel
  import bkpt_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_valid,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_write,
  input  logic          bus_fetch,
  input  logic          we,
  input  reg_sel_e      sel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          trip_nxt,
  output logic          trip_q
);
  logic [AW-1:0]    base_q, mask_q;
  logic [FLD_W-1:0] dir_q, kind_q;
  logic [CW-1:0]    cnt_q, cnt_nxt;
  logic             evt, cnt_we;

  bkpt_match #(.AW(AW)) u_match (
    .base(base_q), .mask(mask_q), .addr(bus_addr), .valid(bus_valid),
    .is_wr(bus_write), .is_fetch(bus_fetch),
    .dir_fld(dir_q), .kind_fld(kind_q), .evt(evt)
  );

  assign cnt_we = we && (sel == SEL_CNT);

  always_comb begin
    cnt_nxt  = cnt_q;
    trip_nxt = trip_q;
    if (cnt_we) begin
      cnt_nxt  = wdata[CW-1:0];
      trip_nxt = 1'b0;
    end else if (evt && !trip_q) begin
      if (cnt_q != '0) cnt_nxt = cnt_q - 1'b1;
      else             trip_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      mask_q <= '0;
      dir_q  <= '0;
      kind_q <= '0;
      cnt_q  <= '0;
      trip_q <= 1'b0;
    end else begin
      if (we && sel == SEL_BASE) base_q <= wdata[AW-1:0];
      if (we && sel == SEL_MASK) mask_q <= wdata[AW-1:0];
      if (we && sel == SEL_CTRL) begin
        dir_q  <= wdata[DIR_LSB +: FLD_W];
        kind_q <= wdata[KIND_LSB +: FLD_W];
      end
      cnt_q  <= cnt_nxt;
      trip_q <= trip_nxt;
    end
  end

  always_comb begin
    rdata = '0;
    case (sel)
      SEL_BASE: rdata[AW-1:0] = base_q;
      SEL_MASK: rdata[AW-1:0] = mask_q;
      SEL_CTRL: begin
        rdata[DIR_LSB +: FLD_W]  = dir_q;
        rdata[KIND_LSB +: FLD_W] = kind_q;
      end
      default:  rdata[CW-1:0] = cnt_q;
    endcase
  end

  assert_dec_R5: assert property (@(posedge clk) disable iff (rst)
    (evt && !cnt_we && !trip_q && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

  assert_fire_R6: assert property (@(posedge clk) disable iff (rst)
    (evt && !cnt_we && cnt_q == '0) |=> trip_q);

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (trip_q && !cnt_we) |=> (trip_q && $stable(cnt_q)));

  assert_rearm_R8: assert property (@(posedge clk) disable iff (rst)
    cnt_we |=> (!trip_q && cnt_q == $past(wdata[CW-1:0])));

  assert_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    (!bus_valid && !cnt_we) |=> ($stable(cnt_q) && trip_q == $past(trip_q)));
endmodule

// File: rtl/bkpt_unit.sv
module bkpt_unit
  import bkpt_pkg::*;
#(
  parameter int AW  = 32,
  parameter int CW  = 16,
  parameter int DW  = 32,
  parameter int NCH = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_valid,
  input  logic [AW-1:0]              bus_addr,
  input  logic                       bus_write,
  input  logic                       bus_fetch,
  input  logic                       reg_we,
  input  logic [$clog2(NCH)+1:0]     reg_addr,
  input  logic [DW-1:0]              reg_wdata,
  output logic [DW-1:0]              reg_rdata,
  output logic                       bkpt_req
);
  localparam int CHW = $clog2(NCH);

  logic [DW-1:0]  ch_rdata [NCH];
  logic [NCH-1:0] trip_nxt, trip_q;
  logic [CHW-1:0] ch_sel;
  reg_sel_e       sel;

  assign ch_sel = reg_addr[CHW+1:2];
  assign sel    = reg_sel_e'(reg_addr[1:0]);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    bkpt_channel #(.AW(AW), .CW(CW), .DW(DW)) u_ch (
      .clk(clk), .rst(rst),
      .bus_valid(bus_valid), .bus_addr(bus_addr),
      .bus_write(bus_write), .bus_fetch(bus_fetch),
      .we(reg_we && ch_sel == CHW'(c)), .sel(sel), .wdata(reg_wdata),
      .rdata(ch_rdata[c]), .trip_nxt(trip_nxt[c]), .trip_q(trip_q[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bkpt_req  <= 1'b0;
      reg_rdata <= '0;
    end else begin
      bkpt_req  <= |trip_nxt;
      reg_rdata <= ch_rdata[ch_sel];
    end
  end

  assert_req_or_R10: assert property (@(posedge clk) disable iff (rst)
    bkpt_req == (|trip_q));

  assert_req_cause_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(bkpt_req) |-> $past(bus_valid));
endmodule

// File: tb/tb_bkpt_unit.sv
module tb_bkpt_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0;
  logic [31:0] bus_addr = '0;
  logic        bus_write = 1'b0;
  logic        bus_fetch = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        bkpt_req;

  int checks = 0;
  int errors = 0;
  logic rd_go = 1'b0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #5 clk = ~clk;

  bkpt_unit dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .bus_write(bus_write), .bus_fetch(bus_fetch), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bkpt_req(bkpt_req)
  );

  // monitor: pops expected read data after the sampling edge
  initial forever begin
    @(posedge clk);
    if (rd_go) begin
      #2;
      begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (reg_rdata !== e) begin
          errors++;
          $display("FAIL %s: rdata actual %h expected %h", t, reg_rdata, e);
        end
      end
    end
  end

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    reg_addr = a; rd_go = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_go = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic ev(input logic [31:0] a, input logic w, input logic f, input logic v);
    @(negedge clk);
    bus_valid = v; bus_addr = a; bus_write = w; bus_fetch = f;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic chk_req(input logic e, input string t);
    checks++;
    if (bkpt_req !== e) begin
      errors++;
      $display("FAIL %s: bkpt_req actual %b expected %b", t, bkpt_req, e);
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk_req(1'b0, "R1");
    for (int i = 0; i < 8; i++) rd(3'(i), 32'h0, "R1");

    // channel A (addr 0..3): read-only, any kind
    wr(3'd0, 32'h1000_0000);
    wr(3'd1, 32'h0000_00FF);
    wr(3'd2, 32'hFFFF_E0E1);      // only [12:8]=0 and [4:0]=1 kept
    wr(3'd3, 32'd2);
    rd(3'd0, 32'h1000_0000, "R9 base");
    rd(3'd2, 32'h0000_0001, "R9 ctrl");
    rd(3'd3, 32'd2, "R9 cnt");

    ev(32'h1000_0034, 1'b0, 1'b0, 1'b1);
    rd(3'd3, 32'd1, "R5 dec");
    ev(32'h1000_0034, 1'b1, 1'b0, 1'b1);
    rd(3'd3, 32'd1, "R3 write ignored");
    ev(32'h1000_0134, 1'b0, 1'b0, 1'b1);
    rd(3'd3, 32'd1, "R2 unmasked bit differs");
    ev(32'h1000_0034, 1'b0, 1'b0, 1'b0);
    rd(3'd3, 32'd1, "R11 valid low");
    ev(32'h1000_00AB, 1'b0, 1'b0, 1'b1);
    rd(3'd3, 32'd0, "R2 masked bits ignored");
    chk_req(1'b0, "R6 not yet");
    ev(32'h1000_0000, 1'b0, 1'b0, 1'b1);
    chk_req(1'b1, "R6 fire");
    ev(32'h1000_0000, 1'b0, 1'b0, 1'b1);
    chk_req(1'b1, "R7 held");
    rd(3'd3, 32'd0, "R7 cnt stable");

    wr(3'd3, 32'd0);
    chk_req(1'b0, "R8 rearm");
    ev(32'h1000_0000, 1'b0, 1'b0, 1'b1);
    chk_req(1'b1, "R6 zero count");
    // write and event in same cycle
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'd3; reg_wdata = 32'd5;
    bus_valid = 1'b1; bus_addr = 32'h1000_0000; bus_write = 1'b0; bus_fetch = 1'b0;
    @(negedge clk);
    reg_we = 1'b0; bus_valid = 1'b0;
    chk_req(1'b0, "R8 write wins");
    rd(3'd3, 32'd5, "R8 loaded");

    wr(3'd2, 32'h0000_0005);
    wr(3'd3, 32'd5);
    ev(32'h1000_0000, 1'b0, 1'b0, 1'b1);
    rd(3'd3, 32'd5, "R3 code 5 disables");
    wr(3'd2, 32'h0000_0003);
    wr(3'd3, 32'd5);
    ev(32'h1000_0000, 1'b1, 1'b0, 1'b1);
    rd(3'd3, 32'd4, "R3 either");
    wr(3'd2, 32'h0000_0000);
    wr(3'd3, 32'd4);

    // channel B (addr 4..7): either direction, fetch only, exact match
    wr(3'd4, 32'h0000_2000);
    wr(3'd6, 32'h0000_0203);
    wr(3'd7, 32'd0);
    rd(3'd3, 32'd4, "R10 A independent");
    ev(32'h0000_2000, 1'b0, 1'b0, 1'b1);
    chk_req(1'b0, "R4 data rejected");
    ev(32'h0000_2001, 1'b0, 1'b1, 1'b1);
    chk_req(1'b0, "R2 mask zero");
    ev(32'h0000_2000, 1'b0, 1'b1, 1'b1);
    chk_req(1'b1, "R4 R10 fetch trips B");
    rd(3'd7, 32'd0, "R10 B cnt");

    wr(3'd6, 32'h0000_0103);
    wr(3'd7, 32'd0);
    chk_req(1'b0, "R8 B rearm");
    ev(32'h0000_2000, 1'b1, 1'b1, 1'b1);
    chk_req(1'b0, "R4 fetch rejected");
    ev(32'h0000_2000, 1'b1, 1'b0, 1'b1);
    chk_req(1'b1, "R4 data trips");
    wr(3'd6, 32'h0000_0703);
    wr(3'd7, 32'd0);
    ev(32'h0000_2000, 1'b0, 1'b0, 1'b1);
    ev(32'h0000_2000, 1'b0, 1'b1, 1'b1);
    chk_req(1'b0, "R4 code 7 never");

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule